// File: doc/BRIEF.md
# Byte-Lane Chip-Select Decoder

This combinational decoder turns the upper address lines of a 16-bit word bus into active-low chip selects for a small set of memory and I/O devices. The bus carries address lines A23 down to A1. There is no A0 line. Each device is a pair of byte-wide parts, so every device slot has two selects: a high-lane select that follows the upper data strobe and a low-lane select that follows the lower data strobe. Nothing is selected unless the address strobe is asserted.

A compile-time parameter picks between two maps. The full-decode map compares every upper address line that lies above each region's size. Its three slots are a 128 KB RAM at 0x480000, a 32 KB EPROM at 0x600000 and a 32 KB RAM at 0x700000. The partial-decode map leaves some upper lines out of the compare, so each location answers at several addresses. Its seven slots are two 1 MB EPROM pairs, four 512 KB RAM pairs and a 64 KB I/O window. An unmapped flag reports a strobed access that hits no slot.

Top module: `bus_cs_decoder`

## Requirements
- R1: While as_ni is high, every bit of cs_hi_no and cs_lo_no is high and unmapped_o is low, whatever the address and data strobes are.
- R2: A bit of cs_hi_no goes low only when as_ni is low, uds_ni is low and the address falls in that slot's region.
- R3: A bit of cs_lo_no goes low only when as_ni is low, lds_ni is low and the address falls in that slot's region. When both data strobes are low, the two lanes select the same slot.
- R4: With FULL_DECODE=1, slot 0 is selected for byte addresses 0x480000 to 0x49FFFF (A23..A17 = 0100100). It is not selected for 0x47FFFE or 0x4A0000.
- R5: With FULL_DECODE=1, slot 1 is selected for 0x600000 to 0x607FFF and slot 2 for 0x700000 to 0x707FFF (A23..A15 compared). The addresses 0x608000 and 0x708000 select nothing.
- R6: With FULL_DECODE=0 the slots are assigned as follows. Slots 0 and 1 are EPROM pairs at 0x000000 and 0x100000, and A20 picks between them. Slots 2 to 5 are RAM pairs at 0x200000, 0x280000, 0x300000 and 0x380000, and A20:A19 picks among them. Slot 6 is the I/O window at 0xFF0000.
- R7: With FULL_DECODE=0, the memory slots compare only A23, A21, A20 and A19, so A22 is ignored and memory aliases at +0x400000. The I/O slot compares only A23..A22 = 11, so it answers anywhere in 0xC00000 to 0xFFFFFF.
- R8: At most one bit of cs_hi_no and at most one bit of cs_lo_no is low at any time.
- R9: unmapped_o is high exactly when as_ni is low and the address hits no slot, independent of the data strobes. With FULL_DECODE=0 this covers 0x800000 to 0xBFFFFF.
- R10: The decoder holds no state. Every output follows its inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 23 | Word address, bus lines A23..A1 |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper (D15..D8) data strobe, active low |
| lds_ni | input | 1 | Lower (D7..D0) data strobe, active low |
| cs_hi_no | output | NDEV | Per-slot high-lane chip select, active low |
| cs_lo_no | output | NDEV | Per-slot low-lane chip select, active low |
| unmapped_o | output | 1 | Strobed access that hits no slot |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between any input and any output. The bench applies inputs just after a falling clock edge and reads the outputs a quarter period later, so a stale or registered path would show up as a mismatch. One check changes the address twice without any clock edge between the changes and expects the selects to follow both times. A full-decode instance and a partial-decode instance receive identical stimulus, and each is compared against the slot that the bench's own table predicts for that mode.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  localparam int unsigned AW = 24;
  localparam int unsigned FULL_SLOTS = 3;
  localparam int unsigned PART_SLOTS = 7;

  // base and care are byte addresses; bit 0 never exists on the bus
  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] care;
  } region_t;

  function automatic int unsigned num_regions(input bit full);
    return full ? FULL_SLOTS : PART_SLOTS;
  endfunction

  function automatic region_t region_of(input bit full, input int unsigned idx);
    region_t r;
    // bit 0 set in base and care: unused slots can never match
    r.base = '1;
    r.care = '1;
    if (full) begin
      case (idx)
        0: begin r.base = 24'h480000; r.care = 24'hFE0000; end
        1: begin r.base = 24'h600000; r.care = 24'hFF8000; end
        2: begin r.base = 24'h700000; r.care = 24'hFF8000; end
        default: ;
      endcase
    end else begin
      if (idx < 2) begin
        r.base = AW'(idx) << 20;
        r.care = 24'hB00000;
      end else if (idx < 6) begin
        r.base = 24'h200000 | (AW'(idx - 2) << 19);
        r.care = 24'hB80000;
      end else if (idx == 6) begin
        r.base = 24'hC00000;
        r.care = 24'hC00000;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/addr_dec_region.sv
module addr_dec_region
  import addr_dec_pkg::*;
#(
  parameter bit          FULL = 1'b1,
  parameter int unsigned IDX  = 0
) (
  input  logic [AW-1:1] addr_i,
  output logic          hit_o
);

  localparam region_t REG = region_of(FULL, IDX);

  logic [AW-1:0] byte_addr;

  assign byte_addr = {addr_i, 1'b0};
  assign hit_o     = ((byte_addr & REG.care) == (REG.base & REG.care));

endmodule

// File: rtl/addr_dec_lane.sv
module addr_dec_lane (
  input  logic hit_i,
  input  logic as_ni,
  input  logic strobe_ni,
  output logic cs_no
);

  assign cs_no = ~(hit_i & ~as_ni & ~strobe_ni);

endmodule

// File: rtl/bus_cs_decoder.sv
module bus_cs_decoder #(
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned NDEV        = addr_dec_pkg::num_regions(FULL_DECODE)
) (
  input  logic [addr_dec_pkg::AW-1:1] addr_i,
  input  logic                        as_ni,
  input  logic                        uds_ni,
  input  logic                        lds_ni,
  output logic [NDEV-1:0]             cs_hi_no,
  output logic [NDEV-1:0]             cs_lo_no,
  output logic                        unmapped_o
);

  logic [NDEV-1:0] hit;

  for (genvar g = 0; g < NDEV; g++) begin : g_slot
    addr_dec_region #(
      .FULL(FULL_DECODE),
      .IDX (g)
    ) u_region (
      .addr_i(addr_i),
      .hit_o (hit[g])
    );

    addr_dec_lane u_hi (
      .hit_i    (hit[g]),
      .as_ni    (as_ni),
      .strobe_ni(uds_ni),
      .cs_no    (cs_hi_no[g])
    );

    addr_dec_lane u_lo (
      .hit_i    (hit[g]),
      .as_ni    (as_ni),
      .strobe_ni(lds_ni),
      .cs_no    (cs_lo_no[g])
    );
  end

  assign unmapped_o = ~as_ni & ~(|hit);

endmodule

// File: rtl/bus_cs_decoder_chk.sv
module bus_cs_decoder_chk #(
  parameter int unsigned NDEV = 3
) (
  input logic            as_ni,
  input logic            uds_ni,
  input logic            lds_ni,
  input logic [NDEV-1:0] cs_hi_no,
  input logic [NDEV-1:0] cs_lo_no,
  input logic            unmapped_o
);

  always_comb begin
    if (as_ni)
      AST_IDLE_WITHOUT_AS: assert ((&cs_hi_no) && (&cs_lo_no) && !unmapped_o) else $error("select without address strobe"); // R1
    if (uds_ni)
      AST_HI_NEEDS_UDS: assert (&cs_hi_no) else $error("high lane without upper strobe"); // R2
    if (lds_ni)
      AST_LO_NEEDS_LDS: assert (&cs_lo_no) else $error("low lane without lower strobe"); // R3
    if (!uds_ni && !lds_ni)
      AST_LANES_AGREE: assert (cs_hi_no == cs_lo_no) else $error("lanes select different slots"); // R3
    AST_ONE_DEVICE: assert ($onehot0(~cs_hi_no) && $onehot0(~cs_lo_no)) else $error("more than one slot"); // R8
    if (unmapped_o)
      AST_UNMAPPED_QUIET: assert (!as_ni && (&cs_hi_no) && (&cs_lo_no)) else $error("unmapped with select"); // R9
  end

endmodule

bind bus_cs_decoder bus_cs_decoder_chk #(.NDEV(NDEV)) u_chk (
  .as_ni     (as_ni),
  .uds_ni    (uds_ni),
  .lds_ni    (lds_ni),
  .cs_hi_no  (cs_hi_no),
  .cs_lo_no  (cs_lo_no),
  .unmapped_o(unmapped_o)
);

// File: tb/tb_bus_cs_decoder.sv
module tb_bus_cs_decoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NONE = 4'hF;

  typedef struct packed {
    logic [23:0] addr;
    logic [3:0]  sf;   // expected slot, full map
    logic [3:0]  sp;   // expected slot, partial map
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{24'h480000, 4'd0, 4'd0, 4'd4},
    '{24'h49FFFE, 4'd0, 4'd0, 4'd4},
    '{24'h47FFFE, NONE, 4'd0, 4'd4},
    '{24'h4A0000, NONE, 4'd0, 4'd4},
    '{24'h600000, 4'd1, 4'd2, 4'd5},
    '{24'h607FFE, 4'd1, 4'd2, 4'd5},
    '{24'h608000, NONE, 4'd2, 4'd5},
    '{24'h5FFFFE, NONE, 4'd1, 4'd5},
    '{24'h700000, 4'd2, 4'd4, 4'd5},
    '{24'h707FFE, 4'd2, 4'd4, 4'd5},
    '{24'h708000, NONE, 4'd4, 4'd5},
    '{24'h000000, NONE, 4'd0, 4'd6},
    '{24'h0FFFFE, NONE, 4'd0, 4'd6},
    '{24'h100000, NONE, 4'd1, 4'd6},
    '{24'h1FFFFE, NONE, 4'd1, 4'd6},
    '{24'h200000, NONE, 4'd2, 4'd6},
    '{24'h280000, NONE, 4'd3, 4'd6},
    '{24'h300000, NONE, 4'd4, 4'd6},
    '{24'h380000, NONE, 4'd5, 4'd6},
    '{24'h3FFFFE, NONE, 4'd5, 4'd6},
    '{24'hFF0000, NONE, 4'd6, 4'd6},
    '{24'hFFFFFE, NONE, 4'd6, 4'd6},
    '{24'h400000, NONE, 4'd0, 4'd7},
    '{24'h780000, NONE, 4'd5, 4'd7},
    '{24'hC00000, NONE, 4'd6, 4'd7},
    '{24'hFEFFFE, NONE, 4'd6, 4'd7},
    '{24'hBFFFFE, NONE, NONE, 4'd9},
    '{24'h800000, NONE, NONE, 4'd9}
  };

  logic        clk;
  logic        rst_ni;
  logic [23:1] addr;
  logic        as_n, uds_n, lds_n;
  logic [2:0]  hi_f, lo_f;
  logic [6:0]  hi_p, lo_p;
  logic        unm_f, unm_p;
  int          n_checks, n_fail;
  bit          done;

  bus_cs_decoder #(.FULL_DECODE(1'b1)) dut (
    .addr_i(addr), .as_ni(as_n), .uds_ni(uds_n), .lds_ni(lds_n),
    .cs_hi_no(hi_f), .cs_lo_no(lo_f), .unmapped_o(unm_f)
  );

  bus_cs_decoder #(.FULL_DECODE(1'b0)) dut_partial (
    .addr_i(addr), .as_ni(as_n), .uds_ni(uds_n), .lds_ni(lds_n),
    .cs_hi_no(hi_p), .cs_lo_no(lo_p), .unmapped_o(unm_p)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd9: return "R9";
      default: return "R2/R3";
    endcase
  endfunction

  function automatic logic [6:0] exp_cs(input logic [3:0] slot, input logic a_n, input logic s_n);
    logic [6:0] r;
    r = '1;
    if (!a_n && !s_n && slot != NONE) r[slot[2:0]] = 1'b0;
    return r;
  endfunction

  task automatic drive(input logic [23:0] a, input logic a_n, input logic u_n, input logic l_n);
    @(negedge clk);
    addr  = a[23:1];
    as_n  = a_n;
    uds_n = u_n;
    lds_n = l_n;
    #(CLK_PERIOD/4);
  endtask

  // compares both instances against the slot each map should select
  task automatic compare(input string req, input logic [3:0] sf, input logic [3:0] sp);
    logic [6:0] ehf, elf, ehp, elp;
    logic euf, eup;
    ehf = exp_cs(sf, as_n, uds_n);
    elf = exp_cs(sf, as_n, lds_n);
    ehp = exp_cs(sp, as_n, uds_n);
    elp = exp_cs(sp, as_n, lds_n);
    euf = !as_n && sf == NONE;
    eup = !as_n && sp == NONE;
    n_checks++;
    if (hi_f != ehf[2:0] || lo_f != elf[2:0] || unm_f != euf) begin
      n_fail++;
      $display("FAIL %s full addr=%h hi=%b lo=%b unm=%b expected hi=%b lo=%b unm=%b",
               req, {addr, 1'b0}, hi_f, lo_f, unm_f, ehf[2:0], elf[2:0], euf);
    end
    n_checks++;
    if (hi_p != ehp || lo_p != elp || unm_p != eup) begin
      n_fail++;
      $display("FAIL %s partial addr=%h hi=%b lo=%b unm=%b expected hi=%b lo=%b unm=%b",
               req, {addr, 1'b0}, hi_p, lo_p, unm_p, ehp, elp, eup);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_ni   = 1'b0;
    addr     = '0;
    as_n     = 1'b1;
    uds_n    = 1'b1;
    lds_n    = 1'b1;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R1 idle state: no address strobe
    drive(24'h000000, 1'b1, 1'b1, 1'b1);
    compare("R1", NONE, NONE);

    // R2 R3 R4 R5 R6 R7 R8 R9: table walk over all data strobe pairs
    for (int i = 0; i < NV; i++) begin
      for (int s = 0; s < 4; s++) begin
        drive(VECS[i].addr, 1'b0, s[1], s[0]);
        compare(req_name(VECS[i].req), VECS[i].sf, VECS[i].sp);
      end
    end

    // R1 strobes low but address strobe high, mapped and unmapped addresses
    drive(24'h480000, 1'b1, 1'b0, 1'b0);
    compare("R1", NONE, NONE);
    drive(24'hFF0000, 1'b1, 1'b0, 1'b0);
    compare("R1", NONE, NONE);
    drive(24'h800000, 1'b1, 1'b0, 1'b0);
    compare("R1", NONE, NONE);

    // R9 unmapped raised with no data strobe at all
    drive(24'h800000, 1'b0, 1'b1, 1'b1);
    compare("R9", NONE, NONE);

    // R10 outputs follow the address with no clock edge in between
    drive(24'h700000, 1'b0, 1'b0, 1'b0);
    compare("R10", 4'd2, 4'd4);
    #1;
    addr = 24'h600000 >> 1;
    #1;
    compare("R10", 4'd1, 4'd2);
    addr = 24'h000000;
    #1;
    compare("R10", NONE, 4'd0);

    // R8 one-hot across a bank boundary in the partial map
    drive(24'h27FFFE, 1'b0, 1'b0, 1'b0);
    compare("R8", NONE, 4'd2);
    drive(24'h280000, 1'b0, 1'b0, 1'b0);
    compare("R8", NONE, 4'd3);

    drive(24'h000000, 1'b1, 1'b1, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule